// File: doc/BRIEF.md
# Supervisory Reset Generator with Chip-Select Watchdog

This block drives the active-low reset line of a host processor. It asserts reset for three reasons. The first is power-up. The second is a supply that falls below its trip point, reported by an external comparator flag. The third is a watchdog that the host fails to service in time.

The host services the watchdog by pulsing the serial chip-select low. Any low run that lasts long enough counts as a service, so ordinary serial traffic keeps the watchdog quiet. Two select bits from a status register choose one of three timeout lengths or turn the watchdog off. A new select value is only taken when a serial command completes or when the block comes out of power-on reset. It is not taken at the moment the status register is written.

All periods are counted in ticks of an external prescaled enable. This lets simulation use short periods while silicon uses millisecond ticks. The output is a pull-low enable for an open-drain pad. The pad never drives the line high, and an external pull-up is assumed.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_ni` is low, `rst_pull_o` is 1. Here 1 means the pad pulls the reset line low. After `rst_ni` rises with the supply good, `rst_pull_o` stays 1 for `POR_TICKS` ticks and then goes to 0.
- R2: The select codes 00, 01 and 10 give watchdog timeouts of `TO_00_TICKS`, `TO_01_TICKS` and `TO_10_TICKS` ticks. A timeout is counted from the last restart of the watchdog count. When it expires, `rst_pull_o` becomes 1.
- R3: Select code 11 disables the watchdog, so no watchdog reset ever occurs.
- R4: A watchdog reset holds `rst_pull_o` at 1 for `RST_TICKS` ticks and then releases it.
- R5: The watchdog count is held at zero while reset is asserted. It starts from zero when reset releases, so the next timeout is the full period again.
- R6: If `cs_ni` stays low for `MIN_LOW` consecutive clock cycles, the watchdog count restarts.
- R7: A low run on `cs_ni` shorter than `MIN_LOW` cycles does not restart the count.
- R8: The select bits are latched only in the first cycle after `rst_ni` rises or in a cycle with `cmd_done_i` high. A change on `wd_sel_i` at any other time has no effect on the running timeout.
- R9: When `supply_ok_i` is low, `rst_pull_o` is 1 from the next clock edge on. After `supply_ok_i` returns high, `rst_pull_o` is released only after `POR_TICKS` ticks.
- R10: A supply-low event during a watchdog reset ends that reset period and replaces it with the power-on period of R9.
- R11: Reset periods and watchdog counts advance only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Prescaled timebase enable, one cycle per tick |
| cs_ni | input | 1 | Serial chip-select, active low; also serves as the watchdog service input |
| supply_ok_i | input | 1 | Supply comparator flag, 1 when the supply is above the trip point |
| wd_sel_i | input | 2 | Watchdog select bits from the status register |
| cmd_done_i | input | 1 | One-cycle pulse when a serial read or write command completes |
| rst_pull_o | output | 1 | Pull-low enable for the open-drain reset pad |

## Verification
The bench measures every period exactly, counted from the cycle it starts. A design off by one register, or one that counts clocks instead of ticks, misses by at least one cycle.

A chip-select low run one cycle shorter than the minimum is placed just after a reset releases. A filter that accepted it would stretch the measured timeout to the full period.

The select bits are changed with no completed command, to catch a design that applies them at once. A supply drop is placed in the middle of a watchdog reset, because that reset is deliberately shorter than the power-on period. A design without the correct priority would release early.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,  // power-on / supply-low hold
    ST_WDR  = 2'd1,  // watchdog-triggered reset period
    ST_RUN  = 2'd2   // reset released
  } rst_state_e;

  localparam logic [1:0] WD_OFF = 2'b11;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sup_kick_filter.sv
module sup_kick_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic kick_o
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam logic [LW-1:0] SAT  = LW'(MIN_LOW);
  localparam logic [LW-1:0] FIRE = LW'(MIN_LOW - 1);

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               low_cnt_q <= '0;
    else if (cs_ni)            low_cnt_q <= '0;
    else if (low_cnt_q != SAT) low_cnt_q <= low_cnt_q + LW'(1);
  end

  // one pulse per qualifying low run
  assign kick_o = !cs_ni && (low_cnt_q == FIRE);

  assert_kick_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !kick_o);
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_pkg::*;
#(
  parameter int TO_00_TICKS = 1400,
  parameter int TO_01_TICKS = 600,
  parameter int TO_10_TICKS = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       kick_i,
  input  logic       cmd_done_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  localparam int TMAX = max3(TO_00_TICKS, TO_01_TICKS, TO_10_TICKS);
  localparam int CW   = $clog2(TMAX + 1);

  logic [1:0]    sel_q;
  logic          init_q;
  logic [CW-1:0] cnt_q, limit_m1;
  logic          en;

  // select applied after power-up or a completed command only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= WD_OFF;
      init_q <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (!init_q || cmd_done_i) sel_q <= sel_i;
    end
  end

  always_comb begin
    unique case (sel_q)
      2'b00:   limit_m1 = CW'(TO_00_TICKS - 1);
      2'b01:   limit_m1 = CW'(TO_01_TICKS - 1);
      2'b10:   limit_m1 = CW'(TO_10_TICKS - 1);
      default: limit_m1 = '0;
    endcase
  end

  assign en       = (sel_q != WD_OFF);
  // >= so a shorter setting taking over a running count still fires
  assign expire_o = run_i && en && tick_i && !kick_i && (cnt_q >= limit_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || kick_i || !en) cnt_q <= '0;
    else if (tick_i)                  cnt_q <= expire_o ? '0 : cnt_q + CW'(1);
  end

  assert_cnt_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  assert_off_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == WD_OFF) |-> !expire_o);
  assert_sel_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !cmd_done_i) |=> $stable(sel_q));
  assert_kick_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0));
endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
  import sup_pkg::*;
#(
  parameter int POR_TICKS = 200,
  parameter int RST_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic wd_expire_i,
  output logic run_o,
  output logic rst_pull_o
);
  localparam int RW = $clog2(((POR_TICKS > RST_TICKS) ? POR_TICKS : RST_TICKS) + 1);
  localparam logic [RW-1:0] POR_END = RW'(POR_TICKS - 1);
  localparam logic [RW-1:0] RST_END = RW'(RST_TICKS - 1);

  rst_state_e    state_q;
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else if (!supply_ok_i) begin
      // supply-low wins over every other state
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: if (tick_i) begin
          if (cnt_q == POR_END) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + RW'(1);
        end
        ST_WDR: if (tick_i) begin
          if (cnt_q == RST_END) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + RW'(1);
        end
        ST_RUN: if (wd_expire_i) begin
          state_q <= ST_WDR;
          cnt_q   <= '0;
        end
        default: begin
          state_q <= ST_HOLD;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign run_o      = (state_q == ST_RUN);
  assign rst_pull_o = (state_q != ST_RUN);

  assert_supply_low_pull_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_pull_o);
  assert_supply_over_wdr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDR && !supply_ok_i) |=> (state_q == ST_HOLD));
  assert_tick_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && supply_ok_i && !wd_expire_i) |=> $stable(state_q) && $stable(cnt_q));
  assert_expire_resets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && wd_expire_i && supply_ok_i) |=> (state_q == ST_WDR));
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int POR_TICKS   = 200,
  parameter int RST_TICKS   = 200,
  parameter int TO_00_TICKS = 1400,
  parameter int TO_01_TICKS = 600,
  parameter int TO_10_TICKS = 200,
  parameter int MIN_LOW     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cs_ni,
  input  logic       supply_ok_i,
  input  logic [1:0] wd_sel_i,
  input  logic       cmd_done_i,
  output logic       rst_pull_o
);
  logic kick, expire, run;

  sup_kick_filter #(.MIN_LOW(MIN_LOW)) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .kick_o (kick)
  );

  sup_wd_timer #(
    .TO_00_TICKS(TO_00_TICKS),
    .TO_01_TICKS(TO_01_TICKS),
    .TO_10_TICKS(TO_10_TICKS)
  ) u_wd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (run),
    .kick_i     (kick),
    .cmd_done_i (cmd_done_i),
    .sel_i      (wd_sel_i),
    .expire_o   (expire)
  );

  sup_reset_seq #(
    .POR_TICKS(POR_TICKS),
    .RST_TICKS(RST_TICKS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .wd_expire_i (expire),
    .run_o       (run),
    .rst_pull_o  (rst_pull_o)
  );

  assert_pull_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> rst_pull_o);
endmodule

// File: tb/sup_reset_gen_tb.sv
module sup_reset_gen_tb;
  localparam int POR = 9;
  localparam int RST = 4;
  localparam int T00 = 20;
  localparam int T01 = 12;
  localparam int T10 = 7;
  localparam int ML  = 3;

  localparam logic [1:0] SEL_TAB [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         TO_TAB  [4] = '{T00, T01, T10, 0};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       cs_ni = 1'b1;
  logic       supply_ok_i = 1'b1;
  logic [1:0] wd_sel_i = 2'b11;
  logic       cmd_done_i = 1'b0;
  logic       rst_pull_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sup_reset_gen #(
    .POR_TICKS(POR), .RST_TICKS(RST),
    .TO_00_TICKS(T00), .TO_01_TICKS(T01), .TO_10_TICKS(T10),
    .MIN_LOW(ML)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cs_ni(cs_ni),
    .supply_ok_i(supply_ok_i), .wd_sel_i(wd_sel_i), .cmd_done_i(cmd_done_i),
    .rst_pull_o(rst_pull_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // count negedges still away from lvl; returns at first negedge showing lvl
  task automatic wait_level(input logic lvl, input int max, output int n);
    n = 0;
    while (n < max) begin
      @(negedge clk);
      if (rst_pull_o == lvl) return;
      n++;
    end
  endtask

  task automatic power_up(input logic [1:0] sel, input string req);
    int n;
    @(negedge clk);
    rst_ni = 1'b0; supply_ok_i = 1'b1; tick_i = 1'b1; cs_ni = 1'b1;
    wd_sel_i = sel;
    repeat (3) @(negedge clk);
    check({req, " pull in reset"}, int'(rst_pull_o), 1);
    rst_ni = 1'b1;
    wait_level(1'b0, 100, n);
    check({req, " power-on period"}, n, POR - 1);
  endtask

  // cs low from now for w edges; caller stands at a negedge
  task automatic kick(input int w);
    cs_ni = 1'b0;
    repeat (w) @(negedge clk);
    cs_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 4; i++) begin
      power_up(SEL_TAB[i], "R1");
      if (TO_TAB[i] > 0) begin
        wait_level(1'b1, 100, n); check("R2 timeout", n, TO_TAB[i] - 1);
        wait_level(1'b0, 100, n); check("R4 wd reset width", n, RST - 1);
        wait_level(1'b1, 100, n); check("R5 full period after release", n, TO_TAB[i] - 1);
        wait_level(1'b0, 100, n);
      end else begin
        wait_level(1'b1, 3 * T00, n); check("R3 disabled", n, 3 * T00);
      end
    end

    // R6: regular kicks hold off the watchdog
    power_up(2'b10, "R1");
    for (int k = 0; k < 5; k++) begin
      kick(ML);
      repeat (3) @(negedge clk);
      check("R6 kicked no reset", int'(rst_pull_o), 0);
    end
    kick(ML);
    wait_level(1'b1, 100, n); check("R6 restart from kick", n, T10 - 1);
    wait_level(1'b0, 100, n);

    // R7: short low run ignored
    kick(ML - 1);
    wait_level(1'b1, 100, n); check("R7 glitch ignored", n, T10 - ML);
    wait_level(1'b0, 100, n);

    // R8: select applied only on command completion
    power_up(2'b10, "R1");
    wd_sel_i = 2'b00;
    wait_level(1'b1, 100, n); check("R8 old select kept", n, T10 - 1);
    wait_level(1'b0, 100, n);
    cmd_done_i = 1'b1;
    @(negedge clk);
    cmd_done_i = 1'b0;
    wait_level(1'b1, 100, n); check("R8 new select after command", n, T00 - 2);

    // R9: supply low
    power_up(2'b11, "R1");
    supply_ok_i = 1'b0;
    @(negedge clk);
    check("R9 pull next edge", int'(rst_pull_o), 1);
    repeat (10) @(negedge clk);
    check("R9 held while low", int'(rst_pull_o), 1);
    supply_ok_i = 1'b1;
    wait_level(1'b0, 100, n); check("R9 power-on after recovery", n, POR - 1);

    // R10: supply low in the middle of a watchdog reset
    power_up(2'b10, "R1");
    wait_level(1'b1, 100, n);
    repeat (2) @(negedge clk);
    supply_ok_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 pull during drop", int'(rst_pull_o), 1);
    supply_ok_i = 1'b1;
    wait_level(1'b0, 100, n); check("R10 power-on replaces wd reset", n, POR - 1);

    // R11: no ticks, no progress
    tick_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R11 watchdog frozen", int'(rst_pull_o), 0);
    tick_i = 1'b1;
    wait_level(1'b1, 100, n); check("R11 resumes on ticks", n, T10 - 1);

    rst_ni = 1'b0; tick_i = 1'b0; wd_sel_i = 2'b11;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (30) @(negedge clk);
    check("R11 power-on frozen", int'(rst_pull_o), 1);
    tick_i = 1'b1;
    wait_level(1'b0, 100, n); check("R11 power-on on ticks", n, POR - 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule